// File: doc/BRIEF.md
# Reuse-Distance Replacement Controller

This block decides which entry of a small fully associative buffer to give up when a new key arrives. It ranks entries by how many distinct other keys were seen between two successive references to the same key. Plain recency alone is not used. Frequently reused keys are marked hot and are never victims. Keys seen once, or reused rarely, are marked cold, and only resident cold keys can be evicted. Keys that have left the buffer keep a history record in a bounded recency stack. A key that returns while its record still exists is recognised as having a short reuse distance and is promoted to hot.

Two stacks hold the state. The main stack is ordered by recency and holds hot keys, resident cold keys and non-resident history records. The cold stack holds only the resident cold keys, in least-recently-used order. Each accepted access returns hit or miss, the evicted key if there is one, and the buffer slot that holds or receives the key. Some accesses require a demotion or stack pruning afterwards. During those cycles `busy` is high and no new access is taken.

Top module: `reuse_dist_repl`

## Requirements
- R1: After reset `busy` and `res_valid` are low and the buffer is empty, so the first access is a miss with no eviction that fills slot 0.
- R2: An access is taken on a clock edge where `acc_valid` is high and `busy` is low. Its results appear with `res_valid` high in the very next cycle. `busy` is high in that cycle exactly when the access needs a demotion or a pruning pass.
- R3: Until HOT_N keys are hot, every missing key becomes hot without eviction and takes the lowest-numbered free slot.
- R4: Once the hot set is full, a missing key becomes cold and is placed at the top of both stacks. It takes the lowest free slot, with no eviction, while the buffer holds fewer than HOT_N+COLD_N keys.
- R5: `hit` is high exactly when the key is resident, and `fill_slot` then reports the slot that holds it. A hot hit moves the key to the top of the main stack.
- R6: A miss on a full buffer evicts the least recently used resident cold key. That key appears on `evict_key` with `evict_valid` high, its slot is reported as `fill_slot` for the new key, and its main-stack record, if any, is kept as non-resident.
- R7: A hit on a resident cold key that still has a main-stack record promotes it to hot. The hot key at the bottom of the main stack is then demoted to the top of the cold stack.
- R8: A hit on a resident cold key without a main-stack record leaves it cold and moves it to the top of both stacks.
- R9: A miss on a key with a non-resident record promotes it to hot, with the same eviction, demotion and pruning as R6 and R7.
- R10: Pruning removes cold entries from the bottom of the main stack until a hot key is at the bottom. Whenever the block is idle, the bottom entry is hot.
- R11: The main stack holds at most 2*(HOT_N+COLD_N) entries. A push onto a full main stack first discards the non-resident record nearest the bottom.
- R12: A scan of distinct keys that are never reused does not evict hot keys. After the scan, the hot keys still hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access request present |
| acc_key | input | KEY_W | Key being accessed |
| busy | output | 1 | Demotion or pruning in progress; access not taken |
| res_valid | output | 1 | Result of the access taken in the previous cycle |
| hit | output | 1 | Key was resident |
| evict_valid | output | 1 | A resident key was evicted |
| evict_key | output | KEY_W | Evicted key |
| fill_slot | output | clog2(HOT_N+COLD_N) | Slot holding (hit) or receiving (miss) the key |

## Verification
Every result is registered on the edge that takes the access. The bench drives the request on a falling edge and samples `res_valid`, `hit`, `evict_valid`, `evict_key`, `fill_slot` and `busy` on the next falling edge, which is one cycle after acceptance. A reference model of both stacks in the bench predicts whether that access leaves the block busy. The bench then waits on falling edges until `busy` drops before it presents the next key, so a stall cycle is never mistaken for a result.

// File: rtl/reuse_dist_pkg.sv
package reuse_dist_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DEMOTE,
    ST_PRUNE
  } ctrl_state_t;

  // Strobes from control to datapath, one cycle at a time.
  typedef struct packed {
    logic accept;       // access taken this cycle
    logic mainMove;     // remove matched entry, push key on main top
    logic mainPush;     // push key on main top (discard oldest record if full)
    logic pushHot;      // pushed entry is hot
    logic evict;        // evict cold-stack bottom
    logic shortRemHit;  // remove matched key from cold stack
    logic shortPushKey; // push access key on cold-stack top
    logic demote;       // move main bottom to cold-stack top
    logic prune;        // drop main bottom
  } ctrl_strobe_t;

endpackage

// File: rtl/reuse_dist_dp.sv
module reuse_dist_dp
  import reuse_dist_pkg::*;
#(
  parameter int KEY_W  = 4,
  parameter int HOT_N  = 3,
  parameter int COLD_N = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  ctrl_strobe_t                     strobe,
  input  logic [KEY_W-1:0]                 accKey,
  output logic                             lkHot,
  output logic                             lkInMain,
  output logic                             lkAtBottom,
  output logic                             lkInShort,
  output logic                             lkHotFull,
  output logic                             lkBufFull,
  output logic                             lkBottomCold,
  output logic                             resValid,
  output logic                             resHit,
  output logic                             resEvict,
  output logic [KEY_W-1:0]                 resEvictKey,
  output logic [$clog2(HOT_N+COLD_N)-1:0]  resSlot
);

  localparam int L      = HOT_N + COLD_N;
  localparam int MDEPTH = 2 * L;
  localparam int MC_W   = $clog2(MDEPTH + 1);
  localparam int SC_W   = $clog2(COLD_N + 1);
  localparam int HC_W   = $clog2(HOT_N + 1);
  localparam int SLOT_W = $clog2(L);

  logic [MDEPTH-1:0][KEY_W-1:0] mKey;
  logic [MDEPTH-1:0]            mHot, mRes;
  logic [MC_W-1:0]              mCnt;
  logic [COLD_N-1:0][KEY_W-1:0] sKey;
  logic [SC_W-1:0]              sCnt;
  logic [L-1:0][KEY_W-1:0]      slotKey;
  logic [L-1:0]                 slotUsed;
  logic [HC_W-1:0]              hotCnt;

  logic [MC_W-1:0]   mIdx, kIdx, rIdx;
  logic [SC_W-1:0]   sIdx, remIdx;
  logic [KEY_W-1:0]  vKey, bottomKey, sItem;
  logic              bottomHot, mFull, resident, doRem, doPush;
  logic [MDEPTH-1:0] preRes, nHot, nRes;
  logic [MDEPTH-1:0][KEY_W-1:0] nKey;
  logic [COLD_N-1:0][KEY_W-1:0] tKey, nsKey;
  logic [SLOT_W-1:0] hitSlot, victimSlot, freeSlot, missSlot;

  // Lookups on current state
  always_comb begin
    lkInMain = 1'b0; lkHot = 1'b0; lkAtBottom = 1'b0; mIdx = '0;
    bottomKey = '0; bottomHot = 1'b0;
    for (int j = 0; j < MDEPTH; j++) begin
      if (MC_W'(j) < mCnt && mKey[j] == accKey) begin
        lkInMain = 1'b1; lkHot = mHot[j]; mIdx = MC_W'(j);
        lkAtBottom = (MC_W'(j) == mCnt - MC_W'(1));
      end
      if (mCnt != '0 && MC_W'(j) == mCnt - MC_W'(1)) begin
        bottomKey = mKey[j]; bottomHot = mHot[j];
      end
    end
    lkInShort = 1'b0; sIdx = '0; vKey = '0;
    for (int j = 0; j < COLD_N; j++) begin
      if (SC_W'(j) < sCnt && sKey[j] == accKey) begin
        lkInShort = 1'b1; sIdx = SC_W'(j);
      end
      if (sCnt != '0 && SC_W'(j) == sCnt - SC_W'(1)) vKey = sKey[j];
    end
    lkBottomCold = (mCnt != '0) && !bottomHot;
    lkHotFull    = (int'(hotCnt) == HOT_N);
    lkBufFull    = (int'(hotCnt) + int'(sCnt) == L);
    mFull        = (int'(mCnt) == MDEPTH);
    resident     = lkHot || lkInShort;
  end

  // Main stack: clear victim record, find oldest record, shift-and-push
  always_comb begin
    kIdx = '0;
    for (int j = 0; j < MDEPTH; j++) begin
      preRes[j] = mRes[j] & ~(strobe.evict && MC_W'(j) < mCnt && mKey[j] == vKey);
      if (MC_W'(j) < mCnt && !preRes[j]) kIdx = MC_W'(j);
    end
    if (strobe.mainMove)  rIdx = mIdx;
    else if (mFull)       rIdx = kIdx;
    else                  rIdx = mCnt;
    nKey = mKey; nHot = mHot; nRes = preRes;
    nKey[0] = accKey; nHot[0] = strobe.pushHot; nRes[0] = 1'b1;
    for (int j = 1; j < MDEPTH; j++) begin
      if (MC_W'(j) <= rIdx) begin
        nKey[j] = mKey[j-1]; nHot[j] = mHot[j-1]; nRes[j] = preRes[j-1];
      end
    end
  end

  // Cold stack: optional removal, then optional push on top
  always_comb begin
    doRem  = strobe.evict || strobe.shortRemHit;
    remIdx = strobe.evict ? sCnt - SC_W'(1) : sIdx;
    doPush = strobe.shortPushKey || strobe.demote;
    sItem  = strobe.demote ? bottomKey : accKey;
    for (int j = 0; j < COLD_N; j++) begin
      tKey[j] = sKey[j];
      if (doRem && SC_W'(j) >= remIdx) tKey[j] = sKey[(j + 1 < COLD_N) ? j + 1 : j];
    end
    nsKey = tKey;
    if (doPush) begin
      nsKey[0] = sItem;
      for (int j = 1; j < COLD_N; j++) nsKey[j] = tKey[j-1];
    end
  end

  // Slot table lookups
  always_comb begin
    hitSlot = '0; victimSlot = '0; freeSlot = '0;
    for (int j = L - 1; j >= 0; j--) begin
      if (slotUsed[j] && slotKey[j] == accKey) hitSlot = SLOT_W'(j);
      if (slotUsed[j] && slotKey[j] == vKey)   victimSlot = SLOT_W'(j);
      if (!slotUsed[j])                        freeSlot = SLOT_W'(j);
    end
    missSlot = strobe.evict ? victimSlot : freeSlot;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mKey <= '0; mHot <= '0; mRes <= '0; mCnt <= '0;
      sKey <= '0; sCnt <= '0; slotKey <= '0; slotUsed <= '0; hotCnt <= '0;
      resValid <= 1'b0; resHit <= 1'b0; resEvict <= 1'b0;
      resEvictKey <= '0; resSlot <= '0;
    end else begin
      resValid <= strobe.accept;
      if (strobe.accept) begin
        resHit      <= resident;
        resEvict    <= strobe.evict;
        resEvictKey <= strobe.evict ? vKey : '0;
        resSlot     <= resident ? hitSlot : missSlot;
        if (!resident) begin
          for (int j = 0; j < L; j++) begin
            if (SLOT_W'(j) == missSlot) begin
              slotKey[j] <= accKey; slotUsed[j] <= 1'b1;
            end
          end
        end
        if (strobe.pushHot && !lkHot) hotCnt <= hotCnt + HC_W'(1);
      end
      if (strobe.accept && (strobe.mainMove || strobe.mainPush)) begin
        mKey <= nKey; mHot <= nHot; mRes <= nRes;
        if (strobe.mainPush && !mFull) mCnt <= mCnt + MC_W'(1);
      end else if (strobe.demote || strobe.prune) begin
        mCnt <= mCnt - MC_W'(1);
      end
      if (strobe.demote) hotCnt <= hotCnt - HC_W'(1);
      if (doRem || doPush) begin
        sKey <= nsKey;
        sCnt <= sCnt - SC_W'(doRem) + SC_W'(doPush);
      end
    end
  end

  AST_MAIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(mCnt) <= MDEPTH); // R11
  AST_HOT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(hotCnt) <= HOT_N); // R3
  AST_RESIDENT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(hotCnt) + int'(sCnt) <= L); // R6
  AST_EVICT_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (resValid && resEvict) |-> !resHit); // R6

endmodule

// File: rtl/reuse_dist_ctrl.sv
module reuse_dist_ctrl
  import reuse_dist_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         accValid,
  input  logic         lkHot,
  input  logic         lkInMain,
  input  logic         lkAtBottom,
  input  logic         lkInShort,
  input  logic         lkHotFull,
  input  logic         lkBufFull,
  input  logic         lkBottomCold,
  output ctrl_strobe_t strobe,
  output logic         busy
);

  ctrl_state_t state, stateNext;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (accValid) begin
          strobe.accept = 1'b1;
          if (lkHot) begin
            strobe.mainMove = 1'b1; strobe.pushHot = 1'b1;
            if (lkAtBottom) stateNext = ST_PRUNE;
          end else if (lkInShort) begin
            strobe.shortRemHit = 1'b1;
            if (lkInMain) begin
              strobe.mainMove = 1'b1; strobe.pushHot = 1'b1; stateNext = ST_DEMOTE;
            end else begin
              strobe.mainPush = 1'b1; strobe.shortPushKey = 1'b1;
            end
          end else if (!lkHotFull) begin
            strobe.mainPush = 1'b1; strobe.pushHot = 1'b1;
          end else begin
            strobe.evict = lkBufFull;
            if (lkInMain) begin
              strobe.mainMove = 1'b1; strobe.pushHot = 1'b1; stateNext = ST_DEMOTE;
            end else begin
              strobe.mainPush = 1'b1; strobe.shortPushKey = 1'b1;
            end
          end
        end
      end
      ST_DEMOTE: begin
        strobe.demote = 1'b1;
        stateNext = ST_PRUNE;
      end
      ST_PRUNE: begin
        if (lkBottomCold) strobe.prune = 1'b1;
        else              stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  assign busy = (state != ST_IDLE);

  AST_IDLE_BOTTOM_HOT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !lkBottomCold); // R10
  AST_DEMOTE_NEEDS_HOT_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DEMOTE) |-> !lkBottomCold); // R7

endmodule

// File: rtl/reuse_dist_repl.sv
module reuse_dist_repl
  import reuse_dist_pkg::*;
#(
  parameter int KEY_W  = 4,
  parameter int HOT_N  = 3,
  parameter int COLD_N = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             acc_valid,
  input  logic [KEY_W-1:0]                 acc_key,
  output logic                             busy,
  output logic                             res_valid,
  output logic                             hit,
  output logic                             evict_valid,
  output logic [KEY_W-1:0]                 evict_key,
  output logic [$clog2(HOT_N+COLD_N)-1:0]  fill_slot
);

  ctrl_strobe_t strobe;
  logic lkHot, lkInMain, lkAtBottom, lkInShort, lkHotFull, lkBufFull, lkBottomCold;

  reuse_dist_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .accValid(acc_valid),
    .lkHot(lkHot), .lkInMain(lkInMain), .lkAtBottom(lkAtBottom),
    .lkInShort(lkInShort), .lkHotFull(lkHotFull), .lkBufFull(lkBufFull),
    .lkBottomCold(lkBottomCold), .strobe(strobe), .busy(busy)
  );

  reuse_dist_dp #(.KEY_W(KEY_W), .HOT_N(HOT_N), .COLD_N(COLD_N)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .accKey(acc_key),
    .lkHot(lkHot), .lkInMain(lkInMain), .lkAtBottom(lkAtBottom),
    .lkInShort(lkInShort), .lkHotFull(lkHotFull), .lkBufFull(lkBufFull),
    .lkBottomCold(lkBottomCold), .resValid(res_valid), .resHit(hit),
    .resEvict(evict_valid), .resEvictKey(evict_key), .resSlot(fill_slot)
  );

  AST_RESULT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !busy) |=> res_valid); // R2
  AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && !busy) |=> !res_valid); // R2

endmodule

// File: tb/reuse_dist_repl_test.sv
module reuse_dist_repl_test;

  localparam int KEY_W  = 4;
  localparam int HOT_N  = 3;
  localparam int COLD_N = 2;
  localparam int L      = HOT_N + COLD_N;
  localparam int MDEPTH = 2 * L;
  localparam int SLOT_W = $clog2(L);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0;
  logic [KEY_W-1:0] acc_key = '0;
  logic busy, res_valid, hit, evict_valid;
  logic [KEY_W-1:0] evict_key;
  logic [SLOT_W-1:0] fill_slot;

  always #2 clk = ~clk;

  reuse_dist_repl #(.KEY_W(KEY_W), .HOT_N(HOT_N), .COLD_N(COLD_N)) uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_key(acc_key),
    .busy(busy), .res_valid(res_valid), .hit(hit), .evict_valid(evict_valid),
    .evict_key(evict_key), .fill_slot(fill_slot)
  );

  int nChecks = 0;
  int nErr = 0;
  bit finished = 0;

  // Reference model state (index 0 = top)
  int mk[$];
  bit mh[$];
  bit mr[$];
  int sk[$];
  int slotK[L];
  bit slotU[L];

  function automatic void mRemove(int i);
    mk.delete(i); mh.delete(i); mr.delete(i);
  endfunction

  function automatic void mPushTop(int k, bit h);
    mk.push_front(k); mh.push_front(h); mr.push_front(1'b1);
  endfunction

  function automatic bit mDiscardIfFull();
    int d = -1;
    if (mk.size() != MDEPTH) return 1'b0;
    foreach (mr[j]) if (!mr[j]) d = j;
    mRemove(d);
    return 1'b1;
  endfunction

  function automatic void demote();
    int b = mk[mk.size()-1];
    mRemove(mk.size()-1);
    sk.push_front(b);
  endfunction

  function automatic bit prune();
    bit p = 1'b0;
    while (mk.size() > 0 && !mh[mk.size()-1]) begin
      mRemove(mk.size()-1); p = 1'b1;
    end
    return p;
  endfunction

  function automatic int slotOf(int k);
    foreach (slotU[j]) if (slotU[j] && slotK[j] == k) return j;
    return -1;
  endfunction

  function automatic int firstFree();
    for (int j = 0; j < L; j++) if (!slotU[j]) return j;
    return -1;
  endfunction

  function automatic void modelReset();
    mk.delete(); mh.delete(); mr.delete(); sk.delete();
    for (int j = 0; j < L; j++) begin slotU[j] = 1'b0; slotK[j] = 0; end
  endfunction

  task automatic modelAccess(input int key, output bit eHit, output bit eEv,
                             output int eKey, output int eSlot, output bit eBusy,
                             output string tag);
    int mi = -1, si = -1, hotN = 0, v;
    bit full, pruned = 1'b0, discarded = 1'b0;
    foreach (mk[j]) if (mk[j] == key) mi = j;
    foreach (sk[j]) if (sk[j] == key) si = j;
    foreach (mh[j]) if (mh[j]) hotN++;
    full = (hotN + sk.size()) == L;
    eEv = 1'b0; eKey = 0; eBusy = 1'b0; eHit = 1'b0; tag = "";
    if (mi >= 0 && mh[mi]) begin
      eHit = 1'b1; eSlot = slotOf(key); tag = "R5";
      eBusy = (mi == mk.size() - 1);
      mRemove(mi); mPushTop(key, 1'b1);
      if (eBusy) pruned = prune();
    end else if (si >= 0) begin
      eHit = 1'b1; eSlot = slotOf(key);
      sk.delete(si);
      if (mi >= 0) begin
        tag = "R5 R7"; eBusy = 1'b1;
        mRemove(mi); mPushTop(key, 1'b1); demote(); pruned = prune();
      end else begin
        tag = "R5 R8";
        discarded = mDiscardIfFull(); mPushTop(key, 1'b0); sk.push_front(key);
      end
    end else if (hotN < HOT_N) begin
      tag = "R3"; eSlot = firstFree();
      slotU[eSlot] = 1'b1; slotK[eSlot] = key;
      mPushTop(key, 1'b1);
    end else begin
      if (full) begin
        eEv = 1'b1; v = sk.pop_back(); eKey = v; tag = "R6";
        foreach (mk[j]) if (mk[j] == v) mr[j] = 1'b0;
        eSlot = slotOf(v); slotK[eSlot] = key;
      end else begin
        tag = "R4"; eSlot = firstFree();
        slotU[eSlot] = 1'b1; slotK[eSlot] = key;
      end
      if (mi >= 0) begin
        tag = {tag, " R9"}; eBusy = 1'b1;
        mRemove(mi); mPushTop(key, 1'b1); demote(); pruned = prune();
      end else begin
        discarded = mDiscardIfFull(); mPushTop(key, 1'b0); sk.push_front(key);
      end
    end
    if (pruned)    tag = {tag, " R10"};
    if (discarded) tag = {tag, " R11"};
  endtask

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic doAccess(input int key, output bit gotHit);
    bit eHit, eEv, eBusy;
    int eKey, eSlot;
    string tag;
    while (busy) @(negedge clk);
    modelAccess(key, eHit, eEv, eKey, eSlot, eBusy, tag);
    acc_valid = 1'b1;
    acc_key = KEY_W'(key);
    @(negedge clk);
    acc_valid = 1'b0;
    gotHit = hit;
    check(res_valid == 1'b1, {tag, " R2"}, "res_valid", int'(res_valid), 1);
    check(busy == eBusy, {tag, " R2"}, "busy", int'(busy), int'(eBusy));
    check(hit == eHit, tag, "hit", int'(hit), int'(eHit));
    check(evict_valid == eEv, tag, "evict_valid", int'(evict_valid), int'(eEv));
    if (eEv) check(int'(evict_key) == eKey, tag, "evict_key", int'(evict_key), eKey);
    check(int'(fill_slot) == eSlot, tag, "fill_slot", int'(fill_slot), eSlot);
  endtask

  task automatic applyReset();
    rst_n = 1'b0;
    acc_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    modelReset();
    @(negedge clk);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nErr++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish();
  end

  initial begin
    bit h;
    int unsigned seed = 32'h1234_5678;
    applyReset();
    // R1: reset state
    check(busy == 1'b0, "R1", "busy", int'(busy), 0);
    check(res_valid == 1'b0, "R1", "res_valid", int'(res_valid), 0);
    doAccess(7, h);
    check(h == 1'b0 && fill_slot == '0, "R1", "first access slot", int'(fill_slot), 0);

    // Warm-up, cold fill, hits
    applyReset();
    for (int k = 1; k <= 5; k++) doAccess(k, h);
    for (int k = 1; k <= 5; k++) doAccess(k, h);

    // Loop one entry larger than the buffer
    applyReset();
    for (int rep = 0; rep < 8; rep++)
      for (int k = 0; k <= L; k++) doAccess(k, h);

    // Scan resistance (R12)
    applyReset();
    for (int rep = 0; rep < 3; rep++)
      for (int k = 1; k <= 3; k++) doAccess(k, h);
    for (int k = 4; k <= 15; k++) doAccess(k, h);
    for (int k = 1; k <= 3; k++) begin
      doAccess(k, h);
      check(h == 1'b1, "R12", "hot key survives scan", int'(h), 1);
    end

    // Mixed-frequency traffic
    applyReset();
    for (int n = 0; n < 600; n++) begin
      int key;
      seed = seed * 32'd1103515245 + 32'd12345;
      if (seed[20:19] != 2'b00) key = int'(seed[24:23]) % 3;
      else                      key = 3 + int'(seed[27:24]) % 13;
      doAccess(key, h);
    end

    // Pair sweep over the full key space
    applyReset();
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        doAccess(a, h);
        doAccess(b, h);
        doAccess(a ^ b, h);
      end

    while (busy) @(negedge clk);
    finish();
  end

endmodule